// File: doc/BRIEF.md
# Byte-Lane Synchronous SRAM Port

One synchronous port onto an on-chip RAM. Each word has two 9-bit lanes: lanes 17..9 form the upper lane and 8..0 the lower lane. On every rising clock edge the port samples two chip selects, two per-lane byte enables, a read/write select, the address and the write data. It then writes or reads any mix of the two lanes.

Read data reaches the outputs in one of two ways. In flow-through mode it arrives in the cycle that follows the sampling edge. In pipelined mode it arrives one clock later. An asynchronous output enable can silence both lanes at any time. The port does not produce high impedance itself: it reports it as a per-lane drive flag beside the data bus, and a pad wrapper turns cleared flags into 'z'. The storage is a plain register array whose depth is a parameter.

Top module: `byte_lane_sram_port`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, lane_oe_o is 2'b00 and rdata_o is all zero.
- R2: The port is deselected when ce0_ni is high or ce1_i is low at a clock edge. A deselected edge writes nothing and leaves lane_oe_o at 2'b00 in the cycle that follows.
- R3: When the port is selected but ub_ni and lb_ni are both high, nothing is written and no lane is driven.
- R4: A selected edge with we_ni low writes wdata_i[17:9] to addr_i when ub_ni is low, and writes wdata_i[8:0] when lb_ni is low. A lane whose enable is high keeps its stored value. A write cycle drives no lane.
- R5: A selected edge with we_ni high reads addr_i. It sets lane_oe_o[1] when ub_ni is low and lane_oe_o[0] when lb_ni is low, and it puts the stored lane values on rdata_o.
- R6: When oe_ni is high, lane_oe_o is 2'b00 combinationally, with no clock edge needed. When oe_ni falls again, a read that is still pending reappears.
- R7: In flow-through mode (pipe_mode_i = 0 at reset), read data and lane flags are valid in the cycle that follows the sampling edge. They clear after the next edge that is not a read.
- R8: In pipelined mode (pipe_mode_i = 1 at reset), data and lane flags appear one cycle later than in flow-through mode.
- R9: The port samples pipe_mode_i only while rst_ni is low. Changing it afterwards has no effect on latency.
- R10: Each rdata_o lane whose lane_oe_o bit is clear reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pipe_mode_i | input | 1 | 1 = pipelined read path, 0 = flow-through; sampled during reset |
| ce0_ni | input | 1 | Active-low chip select |
| ce1_i | input | 1 | Active-high chip select |
| ub_ni | input | 1 | Active-low upper lane enable (bits 17..9) |
| lb_ni | input | 1 | Active-low lower lane enable (bits 8..0) |
| we_ni | input | 1 | 0 = write, 1 = read |
| oe_ni | input | 1 | Asynchronous active-low output enable |
| addr_i | input | AW | Word address, AW = clog2(DEPTH) |
| wdata_i | input | 18 | Write data |
| rdata_o | output | 18 | Read data, zero on undriven lanes |
| lane_oe_o | output | 2 | Per-lane drive flag: bit 1 is the upper lane, bit 0 the lower lane |

## Verification
The hardest situation to reach is the async output enable cutting across a pending read. Lifting oe_ni halfway through a cycle must clear the flags without an edge, and the same data must return when oe_ni drops. The stimulus gets there by issuing a read, toggling oe_ni between edges and checking the flags at each step.

The pipelined path is checked through a second reset with the mode pin high. The bench then flips the mode pin while running, which shows the latency does not follow it. Partial-lane writes are checked by reading back both lanes together. This proves that a lane with its enable high kept its old contents.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;
  localparam int unsigned LANES = 2;
  typedef logic [LANES-1:0] lane_mask_t;
endpackage

// File: rtl/sram_ctrl_decode.sv
module sram_ctrl_decode
  import sram_port_pkg::*;
(
  input  logic       ce0_ni,
  input  logic       ce1_i,
  input  logic       ub_ni,
  input  logic       lb_ni,
  input  logic       we_ni,
  output lane_mask_t wr_lanes_o,
  output lane_mask_t rd_lanes_o
);
  logic       sel;
  lane_mask_t lane_en;

  assign sel        = !ce0_ni && ce1_i;
  assign lane_en    = ~{ub_ni, lb_ni};
  assign wr_lanes_o = (sel && !we_ni) ? lane_en : '0;
  assign rd_lanes_o = (sel &&  we_ni) ? lane_en : '0;
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
  import sram_port_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic          clk_i,
  input  lane_mask_t    wr_lanes_i,
  input  lane_mask_t    rd_lanes_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (wr_lanes_i[l]) mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
      if (rd_lanes_i[l]) rd_q <= mem[addr_i];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sram_read_path.sv
module sram_read_path
  import sram_port_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pipe_i,
  input  logic          oe_ni,
  input  lane_mask_t    rd_lanes_i,
  input  logic [DW-1:0] arr_data_i,
  output logic [DW-1:0] rdata_o,
  output lane_mask_t    lane_oe_o
);
  lane_mask_t    vld1_q, vld2_q, vld;
  logic [DW-1:0] data2_q, data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld1_q  <= '0;
      vld2_q  <= '0;
      data2_q <= '0;
    end else begin
      vld1_q  <= rd_lanes_i;
      vld2_q  <= vld1_q;
      data2_q <= arr_data_i;
    end
  end

  assign vld       = pipe_i ? vld2_q : vld1_q;
  assign data      = pipe_i ? data2_q : arr_data_i;
  // output enable gates asynchronously
  assign lane_oe_o = oe_ni ? '0 : vld;

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign rdata_o[l*LANE_W +: LANE_W] =
      lane_oe_o[l] ? data[l*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/byte_lane_sram_port.sv
module byte_lane_sram_port
  import sram_port_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pipe_mode_i,
  input  logic              ce0_ni,
  input  logic              ce1_i,
  input  logic              ub_ni,
  input  logic              lb_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [LANES-1:0]  lane_oe_o
);
  lane_mask_t    wr_lanes, rd_lanes;
  logic [DW-1:0] arr_data;
  logic          mode_q;

  // mode captured only while held in reset
  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= pipe_mode_i;
  end

  sram_ctrl_decode u_dec (
    .ce0_ni    (ce0_ni),
    .ce1_i     (ce1_i),
    .ub_ni     (ub_ni),
    .lb_ni     (lb_ni),
    .we_ni     (we_ni),
    .wr_lanes_o(wr_lanes),
    .rd_lanes_o(rd_lanes)
  );

  sram_lane_array #(.DEPTH(DEPTH), .LANE_W(LANE_W)) u_arr (
    .clk_i     (clk_i),
    .wr_lanes_i(wr_lanes),
    .rd_lanes_i(rd_lanes),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (arr_data)
  );

  sram_read_path #(.LANE_W(LANE_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pipe_i    (mode_q),
    .oe_ni     (oe_ni),
    .rd_lanes_i(rd_lanes),
    .arr_data_i(arr_data),
    .rdata_o   (rdata_o),
    .lane_oe_o (lane_oe_o)
  );
endmodule

// File: rtl/sram_port_chk.sv
module sram_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mode_q,
  input logic       ce0_ni,
  input logic       ce1_i,
  input logic       ub_ni,
  input logic       lb_ni,
  input logic       we_ni,
  input logic       oe_ni,
  input logic [1:0] lane_oe_o
);
  logic sel;
  assign sel = !ce0_ni && ce1_i;

  p_oe_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> lane_oe_o == 2'b00);

  p_deselect_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && !sel) |=> lane_oe_o == 2'b00);

  p_write_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && sel && !we_ni) |=> lane_oe_o == 2'b00);

  p_flow_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && sel && we_ni) |=> (oe_ni || lane_oe_o == ~$past({ub_ni, lb_ni})));

  p_pipe_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && sel && we_ni) |=> ##1 (oe_ni || lane_oe_o == ~$past({ub_ni, lb_ni}, 2)));

  p_mode_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(mode_q));
endmodule

bind byte_lane_sram_port sram_port_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_q   (mode_q),
  .ce0_ni   (ce0_ni),
  .ce1_i    (ce1_i),
  .ub_ni    (ub_ni),
  .lb_ni    (lb_ni),
  .we_ni    (we_ni),
  .oe_ni    (oe_ni),
  .lane_oe_o(lane_oe_o)
);

// File: tb/sim_byte_lane_sram_port.sv
module sim_byte_lane_sram_port;
  localparam int DEPTH = 256;
  localparam int AW    = 8;

  typedef struct packed {
    logic        ce0_n, ce1, ub_n, lb_n, we_n;
    logic [7:0]  addr;
    logic [17:0] wdata;
    logic [1:0]  exp_oe;
    logic [17:0] exp_data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{0,1,0,0,0, 8'd5,   {9'h1A5,9'h0C3}, 2'b00, 18'h0, 8'd4},               // R4 write both
    '{0,1,0,0,1, 8'd5,   18'h0, 2'b11, {9'h1A5,9'h0C3}, 8'd5},               // R5
    '{0,1,0,1,0, 8'd5,   {9'h111,9'h1FF}, 2'b00, 18'h0, 8'd7},               // R7 drop after read
    '{0,1,0,0,1, 8'd5,   18'h0, 2'b11, {9'h111,9'h0C3}, 8'd4},               // R4 upper only
    '{0,1,1,0,0, 8'd5,   {9'h0AA,9'h055}, 2'b00, 18'h0, 8'd4},
    '{0,1,0,0,1, 8'd5,   18'h0, 2'b11, {9'h111,9'h055}, 8'd4},               // R4 lower only
    '{0,1,0,1,1, 8'd5,   18'h0, 2'b10, {9'h111,9'h000}, 8'd10},              // R10 upper read
    '{0,1,1,0,1, 8'd5,   18'h0, 2'b01, {9'h000,9'h055}, 8'd10},              // R10 lower read
    '{1,1,0,0,0, 8'd5,   {9'h1EE,9'h1EE}, 2'b00, 18'h0, 8'd2},               // R2 ce0 high
    '{0,0,0,0,0, 8'd5,   {9'h1DD,9'h1DD}, 2'b00, 18'h0, 8'd2},               // R2 ce1 low
    '{0,1,0,0,1, 8'd5,   18'h0, 2'b11, {9'h111,9'h055}, 8'd2},
    '{1,1,0,0,1, 8'd5,   18'h0, 2'b00, 18'h0, 8'd2},
    '{0,0,0,0,1, 8'd5,   18'h0, 2'b00, 18'h0, 8'd2},
    '{0,1,1,1,0, 8'd5,   {9'h1CC,9'h1CC}, 2'b00, 18'h0, 8'd3},               // R3
    '{0,1,0,0,1, 8'd5,   18'h0, 2'b11, {9'h111,9'h055}, 8'd3},
    '{0,1,0,0,0, 8'd200, {9'h000,9'h1FF}, 2'b00, 18'h0, 8'd4},
    '{0,1,0,0,1, 8'd200, 18'h0, 2'b11, {9'h000,9'h1FF}, 8'd5},
    '{0,1,1,1,1, 8'd5,   18'h0, 2'b00, 18'h0, 8'd3}
  };

  logic clk_i = 0, rst_ni = 0, pipe_mode_i = 0;
  logic ce0_ni = 1, ce1_i = 0, ub_ni = 1, lb_ni = 1, we_ni = 1, oe_ni = 0;
  logic [AW-1:0] addr_i = '0;
  logic [17:0]   wdata_i = '0;
  logic [17:0]   rdata_o;
  logic [1:0]    lane_oe_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  byte_lane_sram_port #(.DEPTH(DEPTH), .LANE_W(9)) u0 (.*);

  task automatic check(string req, logic [1:0] oe, logic [17:0] d);
    n_chk++;
    if (lane_oe_o !== oe || rdata_o !== d) begin
      n_fail++;
      $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h", req, lane_oe_o, rdata_o, oe, d);
    end
  endtask

  task automatic drive(logic c0, c1, ub, lb, we, logic [7:0] a, logic [17:0] w);
    ce0_ni = c0; ce1_i = c1; ub_ni = ub; lb_ni = lb; we_ni = we; addr_i = a; wdata_i = w;
  endtask

  task automatic do_reset(logic mode);
    @(negedge clk_i);
    rst_ni = 0; pipe_mode_i = mode;
    drive(1, 0, 1, 1, 1, 0, 0);
    repeat (3) @(negedge clk_i);
    check("R1", 2'b00, 18'h0);
    rst_ni = 1;
    @(negedge clk_i);
    check("R1", 2'b00, 18'h0);
  endtask

  initial begin
    do_reset(0);
    // flow-through vector walk
    foreach (VEC[i]) begin
      drive(VEC[i].ce0_n, VEC[i].ce1, VEC[i].ub_n, VEC[i].lb_n, VEC[i].we_n,
            VEC[i].addr, VEC[i].wdata);
      @(negedge clk_i);
      check($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].exp_oe, VEC[i].exp_data);
    end
    // R6: async output enable across a pending read
    drive(0, 1, 0, 0, 1, 8'd5, 0);
    @(negedge clk_i);
    drive(1, 0, 1, 1, 1, 0, 0);
    #1 oe_ni = 1;
    #1 check("R6 off", 2'b00, 18'h0);
    oe_ni = 0;
    #1 check("R6 back", 2'b11, {9'h111, 9'h055});
    // R8 pipelined mode
    do_reset(1);
    drive(0, 1, 0, 0, 0, 8'd7, {9'h0F0, 9'h10F});
    @(negedge clk_i);
    drive(0, 1, 0, 1, 1, 8'd7, 0);
    @(negedge clk_i);
    check("R8 early", 2'b00, 18'h0);
    drive(1, 0, 1, 1, 1, 0, 0);
    pipe_mode_i = 0; // R9: must be ignored
    @(negedge clk_i);
    check("R8 late", 2'b10, {9'h0F0, 9'h000});
    drive(0, 1, 1, 0, 1, 8'd7, 0);
    @(negedge clk_i);
    check("R9 still pipelined", 2'b00, 18'h0);
    drive(1, 0, 1, 1, 1, 0, 0);
    @(negedge clk_i);
    check("R9 late", 2'b01, {9'h000, 9'h10F});
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule